// File: doc/BRIEF.md
# Dual Down-Counter Register Window

This block places two independent down-counting interval timers behind one 4 KB register window. A synchronous word port carries reads and writes. The block routes each access to one of the two channels by byte offset, removing the channel base before the channel decodes it. Near the top of the window it returns a fixed bank of identification bytes. The maskable interrupts of the two channels are merged into a single level output.

Each channel counts on its own tick-enable input, so a single system clock can model two different count rates. A channel can run in free-running, periodic or one-shot mode. Its counter is 16 or 32 bits wide, and its prescaler divides by 1, 16 or 256.

The port has no back-pressure. A read strobe always returns data on the following cycle, and a write strobe always takes effect at the clock edge where it is sampled. Neither strobe ever stalls.

Top module: `dual_timer_regs`

## Requirements
- R1: Byte offsets 0x00–0x1F address channel 0 and 0x20–0x3F address channel 1, with 0x20 removed first. Inside a channel, offset bits [4:2] select the word: 0 sets both the reload value and the counter, 6 sets only the reload value, and both of these read back the reload value. Word 1 reads the counter and ignores writes. Word 2 is control. A write to word 3 clears the interrupt. Word 4 reads the raw interrupt in bit 0, and word 5 reads the masked interrupt in bit 0.
- R2: Reads at 0xFE0, 0xFE4, … 0xFFC return, zero-extended and in this order, 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R3: Reads at 0xF00, 0xF04 and every other unmapped offset return zero. Writes at offset 0x40 and above change no state.
- R4: `rdata` is loaded at the clock edge that samples `rd_en`, and it holds its value on every other cycle.
- R5: The control bits are: bit 0 one-shot, bit 1 32-bit counter (0 means 16-bit), bits 3:2 prescale (01 divides by 16, 10 by 256, anything else by 1), bit 5 interrupt enable, bit 6 periodic, bit 7 run. After reset, control reads 0x20, the reload value reads 0 and the counter reads 0x0000FFFF.
- R6: While a channel runs, each counting step lowers its counter by one. A counting step is the channel's tick pulses divided by the prescale. A control write restarts the prescaler.
- R7: A counting step taken at a counter value of zero sets the raw interrupt. In periodic mode the counter then takes the reload value. In free-running mode (bits 6 and 0 both clear) it takes the all-ones value of its width. In one-shot mode it stays at zero and stops until the next load or control write.
- R8: In 16-bit mode the counter reads, and is compared against zero, on its low 16 bits only.
- R9: A write to word 3 clears the raw interrupt. If a wrapping step happens in the same cycle, the set wins.
- R10: A channel's masked interrupt is its raw interrupt ANDed with control bit 5. `irq` is high whenever either channel's masked interrupt is high.
- R11: Ticks on one channel's tick input never change the other channel's counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 2 | Per-channel count enable, bit i for channel i |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte offset into the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined interrupt level |

## Verification
The assertions assume that `rd_en`, `wr_en` and `tick_en` are known values after reset and that offsets are word-aligned. The interrupt-clear property only claims anything when no tick arrives on that edge and the other channel's interrupt is low. The stimulus keeps within these limits: it drives every strobe for exactly one cycle from the falling edge, it never raises a read and a write together, and it aligns every random offset to a word. The single case where a clear and a wrapping tick coincide falls outside the clear property's precondition on purpose.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;

  localparam int CH_WORD_W = 3;

  typedef enum logic [CH_WORD_W-1:0] {
    W_LOAD_NOW = 3'd0,
    W_COUNT    = 3'd1,
    W_CTRL     = 3'd2,
    W_ACK      = 3'd3,
    W_RAW      = 3'd4,
    W_MASKED   = 3'd5,
    W_LOAD_BG  = 3'd6,
    W_SPARE    = 3'd7
  } ch_word_e;

  localparam logic [1:0] PRE_DIV16  = 2'b01;
  localparam logic [1:0] PRE_DIV256 = 2'b10;

  typedef struct packed {
    logic       run;
    logic       periodic;
    logic       irq_en;
    logic       spare;
    logic [1:0] prescale;
    logic       wide;
    logic       single;
  } ctrl_t;

  localparam logic [7:0] CTRL_RESET = 8'h20;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    id_byte = 8'h04;
      3'd1:    id_byte = 8'h18;
      3'd2:    id_byte = 8'h14;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/dual_timer_prescale.sv
module dual_timer_prescale #(
  parameter int LO_LOG2 = 4,
  parameter int HI_LOG2 = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       run,
  input  logic       tick_en,
  input  logic [1:0] sel,
  output logic       step
);
  import dual_timer_pkg::*;

  logic [HI_LOG2-1:0] pre_cnt;
  logic               lo_full;
  logic               hi_full;

  assign lo_full = &pre_cnt[LO_LOG2-1:0];
  assign hi_full = &pre_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            pre_cnt <= '0;
    else if (clear)        pre_cnt <= '0;
    else if (run && tick_en) pre_cnt <= pre_cnt + 1'b1;
  end

  always_comb begin
    step = 1'b0;
    if (run && tick_en) begin
      case (sel)
        PRE_DIV16:  step = lo_full;
        PRE_DIV256: step = hi_full;
        default:    step = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/dual_timer_channel.sv
module dual_timer_channel #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 tick_en,
  input  logic                                 wr_en,
  input  logic [dual_timer_pkg::CH_WORD_W-1:0] word,
  input  logic [DATA_W-1:0]                    wdata,
  output logic [DATA_W-1:0]                    rdata,
  output logic                                 irq
);
  import dual_timer_pkg::*;

  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl;
  logic [DATA_W-1:0] reload;
  logic [DATA_W-1:0] count;
  logic              raw;
  logic              halted;

  logic [DATA_W-1:0] cnt_mask;
  logic [DATA_W-1:0] cnt_eff;
  logic              step;
  logic              wrap;
  logic              wr_ctrl, wr_now, wr_bg, wr_ack;

  assign cnt_mask = ctrl.wide ? {DATA_W{1'b1}}
                              : {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  assign cnt_eff  = count & cnt_mask;

  assign wr_ctrl = wr_en && (word == W_CTRL);
  assign wr_now  = wr_en && (word == W_LOAD_NOW);
  assign wr_bg   = wr_en && (word == W_LOAD_BG);
  assign wr_ack  = wr_en && (word == W_ACK);

  dual_timer_prescale u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (wr_ctrl),
    .run     (ctrl.run && !halted),
    .tick_en (tick_en),
    .sel     (ctrl.prescale),
    .step    (step)
  );

  assign wrap = step && (cnt_eff == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= ctrl_t'(CTRL_RESET);
      reload <= '0;
      count  <= '1;
      halted <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl   <= ctrl_t'(wdata[CTRL_W-1:0]);
        halted <= 1'b0;
      end
      if (wr_now) begin
        reload <= wdata;
        count  <= wdata;
        halted <= 1'b0;
      end else if (wr_bg) begin
        reload <= wdata;
      end else if (step) begin
        if (wrap) begin
          if (ctrl.single)        halted <= 1'b1;
          else if (ctrl.periodic) count  <= reload;
          else                    count  <= cnt_mask;
        end else begin
          count <= cnt_eff - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      raw <= 1'b0;
    else if (wrap)   raw <= 1'b1;
    else if (wr_ack) raw <= 1'b0;
  end

  assign irq = raw && ctrl.irq_en;

  always_comb begin
    case (ch_word_e'(word))
      W_LOAD_NOW, W_LOAD_BG: rdata = reload;
      W_COUNT:               rdata = cnt_eff;
      W_CTRL:                rdata = DATA_W'(ctrl);
      W_RAW:                 rdata = DATA_W'(raw);
      W_MASKED:              rdata = DATA_W'(irq);
      default:               rdata = '0;
    endcase
  end

endmodule

// File: rtl/dual_timer_regs.sv
module dual_timer_regs #(
  parameter int NUM_CH   = 2,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  import dual_timer_pkg::*;

  localparam int CH_OFF_W  = CH_WORD_W + 2;
  localparam int CH_IDX_W  = $clog2(NUM_CH);
  localparam int CH_TOP    = NUM_CH << CH_OFF_W;
  localparam int ID_BASE   = (1 << ADDR_W) - (8 * 4);

  logic                 chan_region;
  logic                 id_region;
  logic [CH_IDX_W-1:0]  chan_idx;
  logic [CH_WORD_W-1:0] word;
  logic [DATA_W-1:0]    chan_rdata [NUM_CH];
  logic [NUM_CH-1:0]    chan_irq;
  logic [DATA_W-1:0]    rd_mux;

  assign chan_region = (int'(addr) < CH_TOP);
  assign id_region   = (int'(addr) >= ID_BASE);
  assign chan_idx    = addr[CH_OFF_W +: CH_IDX_W];
  assign word        = addr[2 +: CH_WORD_W];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic sel_wr;
    assign sel_wr = wr_en && chan_region && (chan_idx == CH_IDX_W'(i));

    dual_timer_channel #(
      .DATA_W   (DATA_W),
      .NARROW_W (NARROW_W)
    ) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en[i]),
      .wr_en   (sel_wr),
      .word    (word),
      .wdata   (wdata),
      .rdata   (chan_rdata[i]),
      .irq     (chan_irq[i])
    );
  end

  always_comb begin
    if (chan_region)    rd_mux = chan_rdata[chan_idx];
    else if (id_region) rd_mux = DATA_W'(id_byte(word));
    else                rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assign irq = |chan_irq;

endmodule

// File: rtl/dual_timer_regs_chk.sv
module dual_timer_regs_chk #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] tick_en,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NUM_CH-1:0] chan_irq,
  input logic [DATA_W-1:0] rdata,
  input logic              irq
);

  assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  assert_id_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(12'hFE0)) |=> (rdata == DATA_W'(8'h04)));

  assert_test_regs_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == ADDR_W'(12'hF00) || addr == ADDR_W'(12'hF04))) |=> (rdata == '0));

  assert_clear_drops_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(12'h00C) && tick_en == '0 && !chan_irq[1]) |=> !irq);

endmodule

bind dual_timer_regs dual_timer_regs_chk #(
  .NUM_CH (NUM_CH),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_en  (tick_en),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .chan_irq (chan_irq),
  .rdata    (rdata),
  .irq      (irq)
);

// File: tb/dual_timer_regs_tb.sv
`timescale 1ns/1ps
module dual_timer_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  tick_en = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  dual_timer_regs u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  function automatic logic [31:0] exp_id(input int idx);
    logic [7:0] t [8] = '{8'h04, 8'h18, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return {24'h0, t[idx]};
  endfunction

  function automatic logic [31:0] exp_high_read(input logic [11:0] a);
    if (a >= 12'hFE0) return exp_id(int'(a[4:2]));
    return 32'h0;
  endfunction

  function automatic logic [31:0] exp_periodic(input int l, input int n);
    return 32'(l - (n % (l + 1)));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic ticks(input int ch, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_en[ch] = 1'b1;
    end
    @(negedge clk); tick_en = '0;
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R5 reset state
    rd(12'h008, rv); check("R5 ctrl reset", rv, 32'h20);
    rd(12'h000, rv); check("R5 load reset", rv, 32'h0);
    rd(12'h004, rv); check("R5 count reset", rv, 32'h0000FFFF);
    check("R10 irq reset", {31'h0, irq}, 32'h0);

    // R2 id bank
    for (int i = 0; i < 8; i++) begin
      rd(12'hFE0 + 12'(i * 4), rv); check("R2 id byte", rv, exp_id(i));
    end

    // R3 test regs, unmapped, ignored writes
    rd(12'hF00, rv); check("R3 F00", rv, 0);
    rd(12'hF04, rv); check("R3 F04", rv, 0);
    rd(12'h100, rv); check("R3 unmapped", rv, 0);
    wr(12'h040, 32'hDEAD); wr(12'hF00, 32'h1234); wr(12'hFE0, 32'h77);
    rd(12'h000, rv); check("R3 ignored write ch0", rv, 0);
    rd(12'h020, rv); check("R3 ignored write ch1", rv, 0);
    rd(12'hFE0, rv); check("R3 id unchanged", rv, 32'h04);

    // R1 decode and rebasing
    wr(12'h000, 32'h11); wr(12'h020, 32'h22);
    rd(12'h000, rv); check("R1 ch0 load", rv, 32'h11);
    rd(12'h020, rv); check("R1 ch1 load", rv, 32'h22);
    rd(12'h018, rv); check("R1 ch0 bg read", rv, 32'h11);
    rd(12'h038, rv); check("R1 ch1 bg read", rv, 32'h22);
    rd(12'h024, rv); check("R1 ch1 count", rv, 32'h22);
    wr(12'h004, 32'h99);
    rd(12'h004, rv); check("R1 count write ignored", rv, 32'h11);
    wr(12'h018, 32'h5);
    rd(12'h004, rv); check("R1 bg load keeps count", rv, 32'h11);
    rd(12'h000, rv); check("R1 bg load sets reload", rv, 32'h5);

    // R4 hold
    repeat (4) @(negedge clk);
    check("R4 rdata hold", rdata, 32'h5);

    // R7 periodic, R10, R11
    wr(12'h008, 32'hE2); wr(12'h000, 32'd3);
    wr(12'h028, 32'hE2);
    ticks(0, 3);
    rd(12'h004, rv); check("R6 count to zero", rv, 0);
    check("R10 no irq yet", {31'h0, irq}, 0);
    ticks(0, 1);
    rd(12'h004, rv); check("R7 periodic reload", rv, 32'd3);
    check("R10 irq high", {31'h0, irq}, 1);
    rd(12'h010, rv); check("R1 raw", rv, 1);
    rd(12'h014, rv); check("R1 masked", rv, 1);
    rd(12'h024, rv); check("R11 ch1 untouched", rv, 32'h22);

    // R9 clear, set wins
    wr(12'h00C, 0);
    rd(12'h010, rv); check("R9 clear", rv, 0);
    check("R9 irq low", {31'h0, irq}, 0);
    wr(12'h000, 0);
    @(negedge clk); wr_en = 1'b1; addr = 12'h00C; tick_en[0] = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick_en = '0;
    rd(12'h010, rv); check("R9 set wins", rv, 1);

    // R10 mask
    wr(12'h008, 32'hC2);
    check("R10 masked off irq", {31'h0, irq}, 0);
    rd(12'h014, rv); check("R10 masked status", rv, 0);
    rd(12'h010, rv); check("R10 raw kept", rv, 1);
    wr(12'h00C, 0);

    // R6 prescale
    wr(12'h000, 32'd100); wr(12'h008, 32'hE6);
    ticks(0, 15);
    rd(12'h004, rv); check("R6 div16 before", rv, 32'd100);
    ticks(0, 1);
    rd(12'h004, rv); check("R6 div16 step", rv, 32'd99);
    ticks(0, 16);
    rd(12'h004, rv); check("R6 div16 second", rv, 32'd98);
    wr(12'h008, 32'hEA);
    ticks(0, 255);
    rd(12'h004, rv); check("R6 div256 before", rv, 32'd98);
    ticks(0, 1);
    rd(12'h004, rv); check("R6 div256 step", rv, 32'd97);

    // R7 free run, R8 narrow
    wr(12'h008, 32'hA0); wr(12'h00C, 0); wr(12'h000, 32'd2);
    ticks(0, 3);
    rd(12'h004, rv); check("R7 R8 free wrap 16b", rv, 32'h0000FFFF);
    rd(12'h010, rv); check("R7 free wrap irq", rv, 1);
    wr(12'h000, 32'h00012345);
    rd(12'h004, rv); check("R8 narrow read", rv, 32'h2345);

    // R7 one-shot
    wr(12'h008, 32'hA3); wr(12'h00C, 0); wr(12'h000, 32'd2);
    ticks(0, 3);
    rd(12'h004, rv); check("R7 oneshot zero", rv, 0);
    rd(12'h010, rv); check("R7 oneshot irq", rv, 1);
    wr(12'h00C, 0);
    ticks(0, 5);
    rd(12'h004, rv); check("R7 oneshot halted", rv, 0);
    rd(12'h010, rv); check("R7 oneshot no refire", rv, 0);

    // random high reads (R2, R3)
    for (int i = 0; i < 40; i++) begin
      logic [11:0] a;
      if (i % 2 == 0) a = 12'hF00 + 12'($urandom % 256);
      else            a = 12'h040 + 12'($urandom % 4032);
      a[1:0] = 2'b00;
      rd(a, rv); check("R2 R3 random read", rv, exp_high_read(a));
    end

    // random periodic on channel 1 (R6, R7, R11)
    for (int i = 0; i < 12; i++) begin
      int l, n;
      l = 1 + int'($urandom % 20);
      n = int'($urandom % 40);
      wr(12'h02C, 0); wr(12'h020, 32'(l));
      if (n > 0) ticks(1, n);
      rd(12'h024, rv); check("R7 random periodic count", rv, exp_periodic(l, n));
      rd(12'h030, rv); check("R7 random periodic irq", rv, (n > l) ? 1 : 0);
    end
    rd(12'h004, rv); check("R11 ch0 untouched by ch1", rv, 0);

    summary();
  end
endmodule